// File: doc/BRIEF.md
# Eight-Line Prioritised Interrupt Controller

The block merges eight interrupt request lines into a single interrupt line toward a processor. Each line passes through a synchronizer and can be set, one bit per line, to react to rising edges or to follow the line's level. Pending requests are held in a request register. A mask register stops marked lines from reaching the interrupt output. An in-service register records levels that were acknowledged and still await an end-of-interrupt. A priority resolver compares the best unmasked pending request with the best level in service. The interrupt output is raised only when the pending request ranks higher.

The processor answers with a one-cycle acknowledge pulse. One cycle later the block presents an 8-bit vector and a one-cycle valid strobe. The vector is a programmable 5-bit base followed by the 3-bit level. If nothing eligible is pending at acknowledge time, the block answers with level 7 as a spurious response and records nothing in service. Levels leave service by a specific end-of-interrupt that names a level, by a non-specific one that clears the top-ranked level in service, or automatically at acknowledge when auto-EOI is on. Priority is either fixed or rotating. In rotating mode, the level that most recently left service drops to the bottom of the order.

Top module: `irq_hub`

## Requirements
- R1: After reset the mask is clear, all lines are edge mode, the base is 0, priority is fixed, auto-EOI is off, `irqOut` is low and `vecValid` is low.
- R2: An edge-mode line (trigger bit 0) sets its request on a synchronized rising edge. The request is cleared by its acknowledge. A line held high after that acknowledge raises no new request.
- R3: A level-mode line (trigger bit 1, written at `cfgAddr` 1) has a request that follows the synchronized input. If the line drops before acknowledge, the request and `irqOut` fall.
- R4: A line whose mask bit is set (`cfgAddr` 0, bit n for line n) cannot raise `irqOut`, but its request is still kept. Clearing the mask bit then raises `irqOut`.
- R5: In fixed priority, level 0 is highest and level 7 lowest. The acknowledge grants the highest-ranked unmasked pending level, and `vecValid` pulses for one cycle, one cycle after `ackIn`.
- R6: `irqOut` is high only when an unmasked pending level ranks above every level in service.
- R7: A write to `cfgAddr` 3 with bit 3 set clears only the in-service bit of the level in bits 2:0.
- R8: A write to `cfgAddr` 3 with bit 3 clear clears the in-service bit of the highest-ranked level in service.
- R9: With auto-EOI on (`cfgAddr` 2 bit 0), an acknowledge does not set the in-service bit.
- R10: With rotating priority on (`cfgAddr` 2 bit 1), the level just cleared by an end-of-interrupt (or just granted under auto-EOI) becomes the lowest priority, and the next level up becomes the highest.
- R11: An acknowledge while no eligible request exists returns level 7 and sets no in-service bit.
- R12: The vector is `cfgAddr` 2 bits 7:3 as bits 7:3, and the granted level as bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Interrupt request lines, asynchronous |
| ackIn | input | 1 | One-cycle acknowledge pulse |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | 0 mask, 1 trigger mode, 2 control, 3 end-of-interrupt |
| cfgData | input | 8 | Configuration write data |
| irqOut | output | 1 | Interrupt to the processor |
| vecOut | output | 8 | Vector returned for an acknowledge |
| vecValid | output | 1 | One-cycle strobe marking `vecOut` |

## Verification
A change on a request line reaches `irqOut` three rising edges later: two synchronizer stages, then the request register. The bench therefore waits four falling edges before it samples. The vector and its strobe are registered and appear one edge after the acknowledge. A monitor compares them on the falling edge that follows, against a queue filled by the acknowledge task. Mask, trigger and end-of-interrupt writes act on the next edge, and `irqOut` is sampled one falling edge after each write. In-service state is observed through whether `irqOut` rises for a competing request.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int NUM_LINES = 8;
  localparam int LVL_W     = $clog2(NUM_LINES);
  localparam int VEC_W     = 8;
  localparam int BASE_W    = VEC_W - LVL_W;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic                 grant;   // acknowledge granted to lvl
    logic                 spur;    // acknowledge with nothing eligible
    logic [LVL_W-1:0]     lvl;     // level being granted
    logic                 setIsr;  // record grant in service
    logic [NUM_LINES-1:0] isrClr;  // end-of-interrupt clear mask
  } hubStrobe_t;
endpackage

// File: rtl/irq_hub_prio.sv
module irq_hub_prio
  import irq_hub_pkg::*;
(
  input  logic [NUM_LINES-1:0] bits,
  input  logic [LVL_W-1:0]     lowestLvl,
  output logic                 any,
  output logic [LVL_W-1:0]     bestLvl,
  output logic [LVL_W-1:0]     bestRank
);
  // rank 0 is the level just above lowestLvl; scan so the smallest rank wins
  always_comb begin
    any      = 1'b0;
    bestLvl  = '0;
    bestRank = '1;
    for (int r = NUM_LINES - 1; r >= 0; r--) begin
      logic [LVL_W-1:0] idx;
      idx = lowestLvl + LVL_W'(1) + LVL_W'(r);
      if (bits[idx]) begin
        any      = 1'b1;
        bestLvl  = idx;
        bestRank = LVL_W'(r);
      end
    end
  end
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [NUM_LINES-1:0] trigLevel,
  input  logic [NUM_LINES-1:0] maskBits,
  input  logic [LVL_W-1:0]     lowestLvl,
  input  logic [BASE_W-1:0]    vecBase,
  input  hubStrobe_t           st,
  output logic                 irqOut,
  output logic [LVL_W-1:0]     pendLvl,
  output logic                 isrAny,
  output logic [LVL_W-1:0]     isrLvl,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] irqPrev, irr, isr, rise, pend;
  logic                 pendAny;
  logic [LVL_W-1:0]     pendRank, isrRank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      irqPrev <= '0;
    end else begin
      syncQ[0] <= irqIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      irqPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~irqPrev;

  // request register: level lines follow input, edge lines latch until granted
  always_ff @(posedge clk) begin
    if (!rst_n) irr <= '0;
    else begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (trigLevel[i]) irr[i] <= syncQ[SYNC_STAGES-1][i];
        else irr[i] <= (irr[i] & ~(st.grant && st.lvl == LVL_W'(i))) | rise[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) isr <= '0;
    else isr <= (isr & ~st.isrClr)
              | ((st.grant && st.setIsr) ? (NUM_LINES'(1) << st.lvl) : '0);
  end

  assign pend = irr & ~maskBits;

  irq_hub_prio pendRes (.bits(pend), .lowestLvl(lowestLvl),
                        .any(pendAny), .bestLvl(pendLvl), .bestRank(pendRank));
  irq_hub_prio isrRes  (.bits(isr), .lowestLvl(lowestLvl),
                        .any(isrAny), .bestLvl(isrLvl), .bestRank(isrRank));

  assign irqOut = pendAny && (!isrAny || pendRank < isrRank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      vecValid <= st.grant | st.spur;
      if (st.grant)     vecOut <= {vecBase, st.lvl};
      else if (st.spur) vecOut <= {vecBase, LVL_W'(NUM_LINES - 1)};
    end
  end

  p_out_unmasked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> |(irr & ~maskBits));
  p_vec_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.grant || st.spur) |=> vecValid);
  p_spur_no_isr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st.spur && st.isrClr == '0) |=> isr == $past(isr));
  p_auto_no_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st.grant && !st.setIsr && st.isrClr == '0) |=> isr == $past(isr));
  p_eoi_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st.isrClr != '0 && !st.grant) |=> (isr & $past(st.isrClr)) == '0);
endmodule

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ackIn,
  input  logic                 cfgWe,
  input  logic [1:0]           cfgAddr,
  input  logic [7:0]           cfgData,
  input  logic                 irqOut,
  input  logic [LVL_W-1:0]     pendLvl,
  input  logic                 isrAny,
  input  logic [LVL_W-1:0]     isrLvl,
  output logic [NUM_LINES-1:0] maskBits,
  output logic [NUM_LINES-1:0] trigLevel,
  output logic [BASE_W-1:0]    vecBase,
  output logic [LVL_W-1:0]     lowestLvl,
  output hubStrobe_t           st
);
  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_TRIG = 2'd1;
  localparam logic [1:0] ADDR_CTL  = 2'd2;
  localparam logic [1:0] ADDR_EOI  = 2'd3;

  logic autoEoi, rotate, eoiWr, eoiSpec, eoiDo;
  logic [LVL_W-1:0] eoiLvl, rotPtr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskBits  <= '0;
      trigLevel <= '0;
      vecBase   <= '0;
      autoEoi   <= 1'b0;
      rotate    <= 1'b0;
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_MASK: maskBits  <= cfgData[NUM_LINES-1:0];
        ADDR_TRIG: trigLevel <= cfgData[NUM_LINES-1:0];
        ADDR_CTL: begin
          vecBase <= cfgData[VEC_W-1:LVL_W];
          rotate  <= cfgData[1];
          autoEoi <= cfgData[0];
        end
        default: ;
      endcase
    end
  end

  assign eoiWr   = cfgWe && cfgAddr == ADDR_EOI;
  assign eoiSpec = cfgData[3];
  assign eoiLvl  = eoiSpec ? cfgData[LVL_W-1:0] : isrLvl;
  assign eoiDo   = eoiWr && (eoiSpec || isrAny);

  always_comb begin
    st.grant  = ackIn && irqOut;
    st.spur   = ackIn && !irqOut;
    st.lvl    = pendLvl;
    st.setIsr = !autoEoi;
    st.isrClr = eoiDo ? (NUM_LINES'(1) << eoiLvl) : '0;
  end

  // rotation pointer: level that most recently left service
  always_ff @(posedge clk) begin
    if (!rst_n) rotPtr <= LVL_W'(NUM_LINES - 1);
    else if (rotate) begin
      if (eoiDo) rotPtr <= eoiLvl;
      else if (st.grant && autoEoi) rotPtr <= pendLvl;
    end
  end

  assign lowestLvl = rotate ? rotPtr : LVL_W'(NUM_LINES - 1);

  p_rot_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && eoiWr && eoiSpec) |=> lowestLvl == $past(cfgData[LVL_W-1:0]));
  p_ack_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(st.grant && st.spur));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irqIn,
  input  logic       ackIn,
  input  logic       cfgWe,
  input  logic [1:0] cfgAddr,
  input  logic [7:0] cfgData,
  output logic       irqOut,
  output logic [7:0] vecOut,
  output logic       vecValid
);
  hubStrobe_t           st;
  logic [NUM_LINES-1:0] maskBits, trigLevel;
  logic [BASE_W-1:0]    vecBase;
  logic [LVL_W-1:0]     lowestLvl, pendLvl, isrLvl;
  logic                 isrAny;

  irq_hub_ctrl ctrl (
    .clk, .rst_n, .ackIn, .cfgWe, .cfgAddr, .cfgData,
    .irqOut, .pendLvl, .isrAny, .isrLvl,
    .maskBits, .trigLevel, .vecBase, .lowestLvl, .st
  );

  irq_hub_dp #(.SYNC_STAGES(2)) dp (
    .clk, .rst_n, .irqIn, .trigLevel, .maskBits, .lowestLvl, .vecBase, .st,
    .irqOut, .pendLvl, .isrAny, .isrLvl, .vecOut, .vecValid
  );
endmodule

// File: tb/irq_hub_test.sv
module irq_hub_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irqIn = '0;
  logic       ackIn = 1'b0;
  logic       cfgWe = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [7:0] cfgData = '0;
  logic       irqOut, vecValid;
  logic [7:0] vecOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2.5 clk = ~clk;

  irq_hub uut (.clk, .rst_n, .irqIn, .ackIn, .cfgWe, .cfgAddr, .cfgData,
               .irqOut, .vecOut, .vecValid);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkIrq(input logic exp, input string tag);
    check(irqOut === exp, tag, int'(irqOut), int'(exp));
  endtask

  task automatic cfgWrite(input logic [1:0] a, input logic [7:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // driver: queue the expected vector, then pulse the acknowledge
  task automatic doAck(input logic [7:0] exp, input string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
  endtask

  // monitor: compare each vector strobe with the next queued item
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && vecValid) begin
        if (expQ.size() == 0) check(1'b0, "R5 unexpected vector", int'(vecOut), 0);
        else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(vecOut === e, t, int'(vecOut), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    checkIrq(1'b0, "R1 irqOut after reset");
    check(vecValid === 1'b0, "R1 vecValid after reset", int'(vecValid), 0);

    cfgWrite(2'd2, 8'h80);             // base 0x10, fixed, no auto-EOI
    irqIn[3] = 1'b1; tick(4);
    checkIrq(1'b1, "R2 edge raises");
    doAck(8'h83, "R12 vector line 3");
    tick(4);
    checkIrq(1'b0, "R2 held line no retrigger");

    irqIn[5] = 1'b1; tick(4);
    checkIrq(1'b0, "R6 lower blocked by service");
    irqIn[1] = 1'b1; tick(4);
    checkIrq(1'b1, "R6 higher nests");
    doAck(8'h81, "R5 highest wins");
    tick(1);
    cfgWrite(2'd3, 8'h00); tick(1);
    checkIrq(1'b0, "R8 non-specific cleared level 1 only");
    cfgWrite(2'd3, 8'h0B); tick(1);
    checkIrq(1'b1, "R7 specific clears level 3");
    doAck(8'h85, "R5 remaining level 5");
    cfgWrite(2'd3, 8'h00);
    irqIn = '0; tick(4);

    cfgWrite(2'd0, 8'h01);
    irqIn[0] = 1'b1; tick(4);
    checkIrq(1'b0, "R4 masked line silent");
    cfgWrite(2'd0, 8'h00); tick(1);
    checkIrq(1'b1, "R4 unmask raises");
    doAck(8'h80, "R4 vector line 0");
    cfgWrite(2'd3, 8'h00);
    irqIn = '0; tick(4);

    cfgWrite(2'd1, 8'h40);
    irqIn[6] = 1'b1; tick(4);
    checkIrq(1'b1, "R3 level raises");
    irqIn[6] = 1'b0; tick(4);
    checkIrq(1'b0, "R3 level drop clears");
    doAck(8'h87, "R11 spurious returns 7");
    tick(1);
    irqIn[7] = 1'b1; tick(4);
    checkIrq(1'b1, "R11 spurious left no service");
    doAck(8'h87, "R11 real level 7");
    cfgWrite(2'd3, 8'h00);
    irqIn = '0;
    cfgWrite(2'd1, 8'h00); tick(4);

    cfgWrite(2'd2, 8'h81);
    irqIn[4] = 1'b1; tick(4);
    doAck(8'h84, "R9 auto grant 4");
    tick(1);
    irqIn[6] = 1'b1; tick(4);
    checkIrq(1'b1, "R9 no service after auto-EOI");
    doAck(8'h86, "R9 auto grant 6");
    irqIn = '0; tick(4);

    cfgWrite(2'd2, 8'h82);
    irqIn[2] = 1'b1; tick(4);
    doAck(8'h82, "R10 first grant");
    cfgWrite(2'd3, 8'h00);
    irqIn = '0; tick(2);
    irqIn = 8'h12; tick(4);
    doAck(8'h84, "R10 rotated order picks 4");
    cfgWrite(2'd3, 8'h00); tick(1);
    checkIrq(1'b1, "R10 level 1 still pending");
    doAck(8'h81, "R10 then 1");
    cfgWrite(2'd3, 8'h00); tick(1);
    checkIrq(1'b0, "R10 all serviced");
    irqIn = '0; tick(4);

    check(expQ.size() == 0, "R5 all vectors seen", expQ.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule